// File: doc/BRIEF.md
# Machine State Register Write Controller

This block holds a processor's machine state register and applies software writes to it. A write arrives as a value, a one-cycle strobe and a flag that says whether the write may change the hypervisor bit. The incoming value is first reduced by a per-implementation writable-bit mask. When hypervisor changes are not allowed, the current hypervisor bit is kept in place of the incoming one. The filtered value then becomes the new register contents.

A write can also have side effects, depending on which bits changed. A change in either address-translation bit raises a one-cycle TLB flush request and a one-cycle request to leave the current translated code block. A toggle of the temporary-register bit raises a one-cycle request to swap general registers 0 to 3 with their shadow copies. The exception-prefix bit selects the exception vector base. When the power-down bit is written as 1 and an external input permits it, the block halts the core and reports a halt status code.

From the register contents the block also keeps two derived outputs: a memory-translation privilege index and a flags word used by the decoder. A user-only build option keeps the masking and the derived outputs and removes every side effect.

Top module: `msr_wr_ctrl`

## Requirements
- R1: On a write, the stored register equals the written value ANDed with the parameter WR_MASK; bits cleared in WR_MASK always read 0.
- R2: When a write has wr_hv_ok low, the hypervisor bit (position 60) keeps its prior value; when wr_hv_ok is high it takes the masked incoming bit.
- R3: In the cycle after a write that changes the instruction-translation bit (position 5) or the data-translation bit (position 4), tlb_flush and exit_tb are both 1 for exactly one cycle.
- R4: With HAS_TGPR set, bank_swap pulses for one cycle after a write that toggles the temporary-register bit (position 17).
- R5: vec_prefix is 32'hFFF00000 once a write sets the exception-prefix bit (position 6) and 32'h00000000 once a write clears it.
- R6: mmu_idx is 2 when the problem-state bit (position 14) is 0 and the hypervisor bit is 1; otherwise it is 1 minus the problem-state bit. It reflects the register after the same clock edge that stores a write.
- R7: hflags equals the register masked to bits 25, 23, 22, 14, 13, 10, 9, 0, 31, 63 and 60, ORed with ext_flags sampled at the same edge. Bits 11 and 8 (floating-point exception modes) never pass from the register.
- R8: A write with the power-down bit (position 18) at 1 while pwr_down_ok is 1 sets halted and gives status code 1 for one cycle; any other write clears halted; status is 0 otherwise.
- R9: tlb_flush, exit_tb, bank_swap and the halt status code are 0 in any cycle not directly after a write, and the register holds its value without a write.
- R10: Synchronous reset clears the register, vec_prefix, halted, every pulse and hflags, and sets mmu_idx to 1.
- R11: With USER_ONLY set, writes are only masked (no hypervisor preservation), and tlb_flush, exit_tb, bank_swap, halted, status and vec_prefix stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_value | input | XLEN | Value to write |
| wr_hv_ok | input | 1 | Write may change the hypervisor bit |
| pwr_down_ok | input | 1 | Power-down is currently permitted |
| ext_flags | input | XLEN | Flag bits from sources other than the register |
| msr_q | output | XLEN | Current register contents |
| mmu_idx | output | 2 | Translation privilege index |
| hflags | output | XLEN | Derived decoder flags word |
| tlb_flush | output | 1 | One-cycle TLB flush request |
| exit_tb | output | 1 | One-cycle leave-translated-block request |
| bank_swap | output | 1 | One-cycle register bank swap request |
| vec_prefix | output | 32 | Exception vector base |
| halted | output | 1 | Core halted |
| status | output | 2 | Write status code: 0 none, 1 halted |

## Verification
The assertions take wr_en to be a clean one-cycle strobe whose qualifiers (wr_hv_ok, pwr_down_ok) are valid in the same cycle. They also take the register to be changed only through this write port. The bench drives every input on the falling clock edge, holds wr_en low during reset, and separates each write from the next by one idle cycle, so that pulses can be told apart. The sweep goes through all combinations of the seven tracked bits and the hypervisor qualifier against the register state left by the previous write. Pseudo-random filler covers the remaining bits, which include two bits outside the writable mask.

// File: rtl/msr_pkg.sv
package msr_pkg;
  typedef enum logic [1:0] {
    ST_NONE = 2'd0,
    ST_HALT = 2'd1
  } msr_stat_e;
endpackage

// File: rtl/msr_filter.sv
module msr_filter #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] WR_MASK   = '1,
  parameter int          HV_POS    = 60,
  parameter bit          USER_ONLY = 1'b0
) (
  input  logic [XLEN-1:0] wr_value,
  input  logic            hv_ok,
  input  logic            cur_hv,
  output logic [XLEN-1:0] new_value
);
  localparam bit LIVE = !USER_ONLY;
  localparam logic [XLEN-1:0] MASK = WR_MASK[XLEN-1:0];

  always_comb begin
    new_value = wr_value & MASK;
    if (LIVE && !hv_ok) new_value[HV_POS] = cur_hv;
  end
endmodule

// File: rtl/msr_effects.sv
module msr_effects import msr_pkg::*; #(
  parameter bit          USER_ONLY = 1'b0,
  parameter bit          HAS_TGPR  = 1'b1,
  parameter logic [31:0] VEC_HI    = 32'hFFF0_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        pwr_ok,
  input  logic        o_ir, n_ir,
  input  logic        o_dr, n_dr,
  input  logic        o_tg, n_tg,
  input  logic        o_ep, n_ep,
  input  logic        n_pow,
  output logic        flush_q,
  output logic        swap_q,
  output logic [31:0] prefix_q,
  output logic        halted_q,
  output logic [1:0]  stat_q
);
  localparam bit LIVE = !USER_ONLY;
  localparam bit TG_ON = HAS_TGPR;

  logic act;
  assign act = LIVE && wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q  <= 1'b0;
      swap_q   <= 1'b0;
      prefix_q <= '0;
      halted_q <= 1'b0;
      stat_q   <= ST_NONE;
    end else begin
      flush_q <= act && ((o_ir ^ n_ir) || (o_dr ^ n_dr));
      swap_q  <= act && TG_ON && (o_tg ^ n_tg);
      if (act && (o_ep ^ n_ep)) prefix_q <= n_ep ? VEC_HI : 32'h0;
      if (act) halted_q <= n_pow && pwr_ok;
      stat_q  <= (act && n_pow && pwr_ok) ? ST_HALT : ST_NONE;
    end
  end

  // R9: a flush pulse only follows a write strobe
  p_flush_after_wr_r9: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(wr_en));
  // R8: halt status code comes with the halted level
  p_halt_code_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_q == ST_HALT) |-> halted_q);
  // R8: halted only changes after a write
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(halted_q));
endmodule

// File: rtl/msr_derive.sv
module msr_derive #(
  parameter int XLEN   = 64,
  parameter int PR_POS = 14,
  parameter int HV_POS = 60,
  parameter int VR_POS = 25,
  parameter int AP_POS = 23,
  parameter int SA_POS = 22,
  parameter int FP_POS = 13,
  parameter int SE_POS = 10,
  parameter int BE_POS = 9,
  parameter int LE_POS = 0,
  parameter int CM_POS = 31,
  parameter int SF_POS = 63
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] msr_d,
  input  logic [XLEN-1:0] ext_flags,
  output logic [1:0]      mmu_q,
  output logic [XLEN-1:0] hflags_q
);
  localparam logic [XLEN-1:0] ONE = 1;
  localparam logic [XLEN-1:0] FMASK =
    (ONE << VR_POS) | (ONE << AP_POS) | (ONE << SA_POS) | (ONE << PR_POS) |
    (ONE << FP_POS) | (ONE << SE_POS) | (ONE << BE_POS) | (ONE << LE_POS) |
    (ONE << CM_POS) | (ONE << SF_POS) | (ONE << HV_POS);

  logic [XLEN-1:0] sel;
  logic [1:0]      mmu_d;

  for (genvar b = 0; b < XLEN; b++) begin : g_sel
    if (FMASK[b]) begin : g_on
      assign sel[b] = msr_d[b];
    end else begin : g_off
      assign sel[b] = 1'b0;
    end
  end

  always_comb begin
    if (!msr_d[PR_POS] && msr_d[HV_POS]) mmu_d = 2'd2;
    else if (msr_d[PR_POS])              mmu_d = 2'd0;
    else                                 mmu_d = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mmu_q    <= 2'd1;
      hflags_q <= '0;
    end else begin
      mmu_q    <= mmu_d;
      hflags_q <= sel | ext_flags;
    end
  end

  // R6: index is never 3
  p_mmu_range_r6: assert property (@(posedge clk) disable iff (rst)
    mmu_q != 2'd3);
endmodule

// File: rtl/msr_wr_ctrl.sv
module msr_wr_ctrl import msr_pkg::*; #(
  parameter int          XLEN      = 64,
  parameter logic [63:0] WR_MASK   = '1,
  parameter bit          USER_ONLY = 1'b0,
  parameter bit          HAS_TGPR  = 1'b1,
  parameter logic [31:0] VEC_HI    = 32'hFFF0_0000,
  parameter int          HV_POS    = 60,
  parameter int          PR_POS    = 14,
  parameter int          IR_POS    = 5,
  parameter int          DR_POS    = 4,
  parameter int          EP_POS    = 6,
  parameter int          TG_POS    = 17,
  parameter int          POW_POS   = 18,
  parameter int          VR_POS    = 25,
  parameter int          AP_POS    = 23,
  parameter int          SA_POS    = 22,
  parameter int          FP_POS    = 13,
  parameter int          SE_POS    = 10,
  parameter int          BE_POS    = 9,
  parameter int          LE_POS    = 0,
  parameter int          CM_POS    = 31,
  parameter int          SF_POS    = 63
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_value,
  input  logic            wr_hv_ok,
  input  logic            pwr_down_ok,
  input  logic [XLEN-1:0] ext_flags,
  output logic [XLEN-1:0] msr_q,
  output logic [1:0]      mmu_idx,
  output logic [XLEN-1:0] hflags,
  output logic            tlb_flush,
  output logic            exit_tb,
  output logic            bank_swap,
  output logic [31:0]     vec_prefix,
  output logic            halted,
  output logic [1:0]      status
);
  localparam logic [XLEN-1:0] MASK = WR_MASK[XLEN-1:0];

  logic [XLEN-1:0] v_new, msr_d;
  logic            flush_q;

  msr_filter #(
    .XLEN(XLEN), .WR_MASK(WR_MASK), .HV_POS(HV_POS), .USER_ONLY(USER_ONLY)
  ) u_filter (
    .wr_value (wr_value),
    .hv_ok    (wr_hv_ok),
    .cur_hv   (msr_q[HV_POS]),
    .new_value(v_new)
  );

  assign msr_d = wr_en ? v_new : msr_q;

  always_ff @(posedge clk) begin
    if (rst) msr_q <= '0;
    else     msr_q <= msr_d;
  end

  msr_effects #(
    .USER_ONLY(USER_ONLY), .HAS_TGPR(HAS_TGPR), .VEC_HI(VEC_HI)
  ) u_effects (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .pwr_ok  (pwr_down_ok),
    .o_ir    (msr_q[IR_POS]),  .n_ir(v_new[IR_POS]),
    .o_dr    (msr_q[DR_POS]),  .n_dr(v_new[DR_POS]),
    .o_tg    (msr_q[TG_POS]),  .n_tg(v_new[TG_POS]),
    .o_ep    (msr_q[EP_POS]),  .n_ep(v_new[EP_POS]),
    .n_pow   (v_new[POW_POS]),
    .flush_q (flush_q),
    .swap_q  (bank_swap),
    .prefix_q(vec_prefix),
    .halted_q(halted),
    .stat_q  (status)
  );

  assign tlb_flush = flush_q;
  assign exit_tb   = flush_q;

  msr_derive #(
    .XLEN(XLEN), .PR_POS(PR_POS), .HV_POS(HV_POS), .VR_POS(VR_POS),
    .AP_POS(AP_POS), .SA_POS(SA_POS), .FP_POS(FP_POS), .SE_POS(SE_POS),
    .BE_POS(BE_POS), .LE_POS(LE_POS), .CM_POS(CM_POS), .SF_POS(SF_POS)
  ) u_derive (
    .clk      (clk),
    .rst      (rst),
    .msr_d    (msr_d),
    .ext_flags(ext_flags),
    .mmu_q    (mmu_idx),
    .hflags_q (hflags)
  );

  // R1: bits outside the writable mask never appear
  p_masked_r1: assert property (@(posedge clk) disable iff (rst)
    (msr_q & ~MASK) == '0);
  // R9: without a write the register holds
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(msr_q));
  // R4: a swap pulse follows a toggle of the temporary-register bit
  p_swap_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    bank_swap |-> (msr_q[TG_POS] != $past(msr_q[TG_POS])));
  // R3: a flush pulse follows a translation bit change
  p_flush_cause_r3: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> ((msr_q[IR_POS] != $past(msr_q[IR_POS])) ||
                   (msr_q[DR_POS] != $past(msr_q[DR_POS]))));

  if (!USER_ONLY) begin : g_full_chk
    // R2: a write without permission keeps the hypervisor bit
    p_hv_keep_r2: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en && !wr_hv_ok) |-> (msr_q[HV_POS] == $past(msr_q[HV_POS])));
    // R5: the vector base follows the stored prefix bit
    p_prefix_r5: assert property (@(posedge clk) disable iff (rst)
      vec_prefix == (msr_q[EP_POS] ? VEC_HI : 32'h0));
  end else begin : g_uo_chk
    // R11: no side effects in the user-only build
    p_uo_quiet_r11: assert property (@(posedge clk) disable iff (rst)
      !tlb_flush && !bank_swap && !halted && (vec_prefix == 32'h0));
  end
endmodule

// File: tb/msr_wr_ctrl_bench.sv
module msr_wr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] WMASK = ~64'h0000_0100_0000_0002;
  localparam int HV = 60, PR = 14, IR = 5, DR = 4, EP = 6, TG = 17, PW = 18;
  localparam logic [63:0] FM =
    (64'd1 << 25) | (64'd1 << 23) | (64'd1 << 22) | (64'd1 << 14) |
    (64'd1 << 13) | (64'd1 << 10) | (64'd1 << 9)  | (64'd1 << 0)  |
    (64'd1 << 31) | (64'd1 << 63) | (64'd1 << 60);

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_hv_ok = 1'b0, pwr_down_ok = 1'b0;
  logic [63:0] wr_value = '0, ext_flags = '0;

  logic [63:0] msr_a, hfl_a, msr_b, hfl_b;
  logic [1:0]  mmu_a, st_a, mmu_b, st_b;
  logic        fl_a, ex_a, sw_a, hl_a, fl_b, ex_b, sw_b, hl_b;
  logic [31:0] pf_a, pf_b;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msr_wr_ctrl #(.WR_MASK(WMASK)) u_msr_wr_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_value(wr_value),
    .wr_hv_ok(wr_hv_ok), .pwr_down_ok(pwr_down_ok), .ext_flags(ext_flags),
    .msr_q(msr_a), .mmu_idx(mmu_a), .hflags(hfl_a), .tlb_flush(fl_a),
    .exit_tb(ex_a), .bank_swap(sw_a), .vec_prefix(pf_a), .halted(hl_a),
    .status(st_a));

  msr_wr_ctrl #(.WR_MASK(WMASK), .USER_ONLY(1'b1)) u_uo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_value(wr_value),
    .wr_hv_ok(wr_hv_ok), .pwr_down_ok(pwr_down_ok), .ext_flags(ext_flags),
    .msr_q(msr_b), .mmu_idx(mmu_b), .hflags(hfl_b), .tlb_flush(fl_b),
    .exit_tb(ex_b), .bank_swap(sw_b), .vec_prefix(pf_b), .halted(hl_b),
    .status(st_b));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] nxt(logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic logic [1:0] mmu_of(logic [63:0] m);
    if (!m[PR] && m[HV]) return 2'd2;
    return m[PR] ? 2'd0 : 2'd1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ma, mb, v, rnd;
    logic hl, ef, sw, hp;
    ma = '0; mb = '0; hl = 1'b0;
    rnd = 64'h9E37_79B9_7F4A_7C15;
    ext_flags = 64'h0000_0000_0000_0800;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 msr", msr_a, 64'h0);
    chk("R10 mmu", {62'h0, mmu_a}, 64'd1);
    chk("R10 hflags", hfl_a, 64'h0);
    chk("R10 pulses", {60'h0, fl_a, ex_a, sw_a, hl_a}, 64'h0);
    chk("R10 prefix", {32'h0, pf_a}, 64'h0);
    chk("R10 status", {62'h0, st_a}, 64'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 ext only", hfl_a, 64'h0000_0000_0000_0800);

    for (int i = 0; i < 512; i++) begin
      rnd = nxt(rnd);
      v = rnd | 64'h0000_0100_0000_0002;
      v[IR] = i[0]; v[DR] = i[1]; v[TG] = i[2]; v[EP] = i[3];
      v[PW] = i[4]; v[HV] = i[5]; v[PR] = i[6];
      wr_value = v; wr_hv_ok = i[7]; pwr_down_ok = i[8] ^ rnd[40];
      ext_flags = {rnd[31:0], rnd[63:32]} & 64'h0F0F_00F0_0000_0100;
      wr_en = 1'b1;
      // model, full build
      v = wr_value & WMASK;
      if (!wr_hv_ok) v[HV] = ma[HV];
      ef = (v[IR] != ma[IR]) || (v[DR] != ma[DR]);
      sw = (v[TG] != ma[TG]);
      hp = v[PW] && pwr_down_ok;
      hl = hp;
      ma = v;
      mb = wr_value & WMASK;
      @(negedge clk);
      chk("R1 msr", msr_a, ma);
      chk("R2 hv", {63'h0, msr_a[HV]}, {63'h0, ma[HV]});
      chk("R3 flush", {63'h0, fl_a}, {63'h0, ef});
      chk("R3 exit", {63'h0, ex_a}, {63'h0, ef});
      chk("R4 swap", {63'h0, sw_a}, {63'h0, sw});
      chk("R5 prefix", {32'h0, pf_a}, ma[EP] ? 64'hFFF0_0000 : 64'h0);
      chk("R6 mmu", {62'h0, mmu_a}, {62'h0, mmu_of(ma)});
      chk("R7 hflags", hfl_a, (ma & FM) | ext_flags);
      chk("R8 halted", {63'h0, hl_a}, {63'h0, hl});
      chk("R8 status", {62'h0, st_a}, hp ? 64'd1 : 64'd0);
      chk("R11 uo msr", msr_b, mb);
      chk("R11 uo quiet", {60'h0, fl_b, ex_b, sw_b, hl_b}, 64'h0);
      chk("R11 uo status", {30'h0, pf_b, st_b}, 64'h0);
      chk("R11 uo mmu", {62'h0, mmu_b}, {62'h0, mmu_of(mb)});
      // idle cycle
      wr_en = 1'b0;
      wr_value = ~wr_value;
      ext_flags = rnd;
      @(negedge clk);
      chk("R9 hold", msr_a, ma);
      chk("R9 no pulse", {61'h0, fl_a, ex_a, sw_a}, 64'h0);
      chk("R9 no status", {62'h0, st_a}, 64'h0);
      chk("R8 halt held", {63'h0, hl_a}, {63'h0, hl});
      chk("R7 ext merge", hfl_a, (ma & FM) | rnd);
      chk("R7 fe excluded", {62'h0, hfl_a[11] & ~rnd[11], hfl_a[8] & ~rnd[8]}, 64'h0);
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule